// File: doc/BRIEF.md
# PHY Management Configuration Controller

This block holds the per-port configuration registers of a multi-port 10/100 Ethernet PHY and decides each port's power state. A synchronous hardware reset samples a mode strap. High selects strap control, and low selects management control. The same reset snapshots one configuration strap word per port. That snapshot loads the control register and is kept for later software resets. A simple parallel register port stands in for the serial management interface. It takes a port select, a register address and 16-bit data, and it returns read data one cycle after the request.

A port powers down when its control-register power bit is set, or when the global power-down pin is high. A powered-down port drops its datapath clock enable and blocks its transmit and receive enables. Global power-down also freezes the register section. Every register value survives until the pin is released.

Top module: `phy_mgmt_ctrl`

## Requirements
- R1: On a cycle with `hw_rst_i` high, `mode_strap_i` is captured. From the next cycle `hw_ctrl_o` shows it, and it holds until the next hardware reset.
- R2: While `hw_ctrl_o` is 1, management writes change no register. Reads still return register contents.
- R3: Hardware reset loads each port's control register (address 0) from its strap word with bit 15 cleared. It loads the advertisement register (address 4) with 16'h01E1, and it latches the cleared strap word.
- R4: Writing address 0 with bit 15 set is a software reset of that port. The control register reloads the strap word latched at the last hardware reset, not the current pins, and the advertisement register returns to 16'h01E1. Bit 15 always reads 0.
- R5: Control bit 11 set powers its port down: `port_pd_o` goes 1 and `port_clk_en_o` goes 0. The port's registers stay readable and writable.
- R6: While `gpd_i` is high every port reports power-down, reads return 0 and writes are dropped. All register contents are unchanged after release.
- R7: A powered-down port drives `tx_en_o` and `rx_en_o` to 0 whatever its requests. Otherwise they follow `tx_req_i` and `rx_req_i`.
- R8: Reads of any address other than 0 and 4 return 0.
- R9: A read request sampled on a clock edge gives `reg_rvalid_o`=1 with its data in the following cycle only.
- R10: Hardware reset takes priority over global power-down and over a write or software reset in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| hw_rst_i | input | 1 | Synchronous active-high hardware reset |
| mode_strap_i | input | 1 | Control-mode strap, 1 = strap control |
| cfg_strap_i | input | NUM_PORTS*16 | Per-port control strap words, port p at [16p+15:16p] |
| gpd_i | input | 1 | Global power-down, active high |
| reg_wr_i | input | 1 | Register write request |
| reg_rd_i | input | 1 | Register read request |
| reg_port_i | input | PSEL_W | Port select |
| reg_addr_i | input | 5 | Register address |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data |
| reg_rvalid_o | output | 1 | Read data valid |
| tx_req_i | input | NUM_PORTS | Per-port transmit request |
| rx_req_i | input | NUM_PORTS | Per-port receive request |
| hw_ctrl_o | output | 1 | Captured control mode |
| port_pd_o | output | NUM_PORTS | Per-port power-down |
| port_clk_en_o | output | NUM_PORTS | Per-port datapath clock enable |
| tx_en_o | output | NUM_PORTS | Gated transmit enable |
| rx_en_o | output | NUM_PORTS | Gated receive enable |

## Verification
A write or a reset affects register contents from the first cycle after the edge that samples it. Read data and its valid flag arrive exactly one cycle after the request edge. The power-down and enable outputs follow the register state and `gpd_i` in the same cycle. The bench drives and samples on falling edges. A scoreboard queue holds each expected read and is drained on the falling edge that follows the request, and a read that is still queued one step later is reported against R9.

// File: rtl/phy_mgmt_pkg.sv
package phy_mgmt_pkg;
    localparam int REG_W      = 16;
    localparam int RADDR_W    = 5;
    localparam int CTRL_ADDR  = 0;
    localparam int ADV_ADDR   = 4;
    localparam int SWRST_BIT  = 15;
    localparam int PDN_BIT    = 11;
    localparam logic [REG_W-1:0] ADV_DEFAULT = 16'h01E1;
    localparam logic [REG_W-1:0] SWRST_MASK  = ~(REG_W'(1) << SWRST_BIT);
endpackage

// File: rtl/phy_mgmt_port.sv
module phy_mgmt_port
    import phy_mgmt_pkg::*;
(
    input  logic               clk,
    input  logic               hw_rst_i,
    input  logic [REG_W-1:0]   strap_i,
    input  logic               wr_en_i,
    input  logic [RADDR_W-1:0] addr_i,
    input  logic [REG_W-1:0]   wdata_i,
    input  logic               gpd_i,
    input  logic               tx_req_i,
    input  logic               rx_req_i,
    output logic [REG_W-1:0]   ctrl_o,
    output logic [REG_W-1:0]   adv_o,
    output logic               pd_o,
    output logic               clk_en_o,
    output logic               tx_en_o,
    output logic               rx_en_o
);
    typedef struct packed {
        logic [REG_W-1:0] ctrl;
        logic [REG_W-1:0] adv;
        logic [REG_W-1:0] snap;
    } port_state_t;

    port_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (hw_rst_i) begin
            st_d.snap = strap_i & SWRST_MASK;
            st_d.ctrl = strap_i & SWRST_MASK;
            st_d.adv  = ADV_DEFAULT;
        end else if (wr_en_i && !gpd_i) begin
            if (addr_i == RADDR_W'(CTRL_ADDR)) begin
                if (wdata_i[SWRST_BIT]) begin
                    st_d.ctrl = st_q.snap;
                    st_d.adv  = ADV_DEFAULT;
                end else begin
                    st_d.ctrl = wdata_i & SWRST_MASK;
                end
            end else if (addr_i == RADDR_W'(ADV_ADDR)) begin
                st_d.adv = wdata_i;
            end
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign ctrl_o   = st_q.ctrl;
    assign adv_o    = st_q.adv;
    assign pd_o     = gpd_i | st_q.ctrl[PDN_BIT];
    assign clk_en_o = ~pd_o;
    assign tx_en_o  = tx_req_i & clk_en_o;
    assign rx_en_o  = rx_req_i & clk_en_o;

    // R4: software reset reloads the hardware-reset snapshot
    a_r4_swrst_reload: assert property (@(posedge clk) disable iff (hw_rst_i)
        (wr_en_i && !gpd_i && addr_i == RADDR_W'(CTRL_ADDR) && wdata_i[SWRST_BIT])
        |=> (ctrl_o == $past(st_q.snap)) && (adv_o == ADV_DEFAULT));

    // R6: global power-down freezes the register section
    a_r6_gpd_hold: assert property (@(posedge clk) disable iff (hw_rst_i)
        gpd_i |=> $stable(ctrl_o) && $stable(adv_o));
endmodule

// File: rtl/phy_mgmt_rdmux.sv
module phy_mgmt_rdmux
    import phy_mgmt_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PSEL_W    = 3
) (
    input  logic                              clk,
    input  logic                              hw_rst_i,
    input  logic                              rd_i,
    input  logic [PSEL_W-1:0]                 port_i,
    input  logic [RADDR_W-1:0]                addr_i,
    input  logic                              gpd_i,
    input  logic [NUM_PORTS-1:0][REG_W-1:0]   ctrl_all_i,
    input  logic [NUM_PORTS-1:0][REG_W-1:0]   adv_all_i,
    output logic [REG_W-1:0]                  rdata_o,
    output logic                              rvalid_o
);
    typedef struct packed {
        logic [REG_W-1:0] data;
        logic             valid;
    } rd_state_t;

    rd_state_t rd_d, rd_q;
    logic [REG_W-1:0] sel;

    always_comb begin
        sel = '0;
        if (int'(port_i) < NUM_PORTS) begin
            if (addr_i == RADDR_W'(CTRL_ADDR))     sel = ctrl_all_i[port_i];
            else if (addr_i == RADDR_W'(ADV_ADDR)) sel = adv_all_i[port_i];
        end
    end

    always_comb begin
        rd_d = rd_q;
        rd_d.valid = 1'b0;
        if (hw_rst_i) begin
            rd_d = '0;
        end else if (rd_i) begin
            rd_d.valid = 1'b1;
            rd_d.data  = gpd_i ? '0 : sel;
        end
    end

    always_ff @(posedge clk) begin
        rd_q <= rd_d;
    end

    assign rdata_o  = rd_q.data;
    assign rvalid_o = rd_q.valid;

    // R9: one-cycle read latency
    a_r9_read_latency: assert property (@(posedge clk) disable iff (hw_rst_i)
        rd_i |=> rvalid_o);
    a_r9_no_spurious: assert property (@(posedge clk) disable iff (hw_rst_i)
        !rd_i |=> !rvalid_o);
    // R8: unimplemented address reads as zero
    a_r8_unimpl_zero: assert property (@(posedge clk) disable iff (hw_rst_i)
        (rd_i && addr_i != RADDR_W'(CTRL_ADDR) && addr_i != RADDR_W'(ADV_ADDR))
        |=> rdata_o == '0);
    // R6: reads under global power-down return zero
    a_r6_gpd_read_zero: assert property (@(posedge clk) disable iff (hw_rst_i)
        (rd_i && gpd_i) |=> rdata_o == '0);
endmodule

// File: rtl/phy_mgmt_ctrl.sv
module phy_mgmt_ctrl
    import phy_mgmt_pkg::*;
#(
    parameter int NUM_PORTS = 8,
    parameter int PSEL_W    = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                       clk,
    input  logic                       hw_rst_i,
    input  logic                       mode_strap_i,
    input  logic [NUM_PORTS*REG_W-1:0] cfg_strap_i,
    input  logic                       gpd_i,
    input  logic                       reg_wr_i,
    input  logic                       reg_rd_i,
    input  logic [PSEL_W-1:0]          reg_port_i,
    input  logic [RADDR_W-1:0]         reg_addr_i,
    input  logic [REG_W-1:0]           reg_wdata_i,
    output logic [REG_W-1:0]           reg_rdata_o,
    output logic                       reg_rvalid_o,
    input  logic [NUM_PORTS-1:0]       tx_req_i,
    input  logic [NUM_PORTS-1:0]       rx_req_i,
    output logic                       hw_ctrl_o,
    output logic [NUM_PORTS-1:0]       port_pd_o,
    output logic [NUM_PORTS-1:0]       port_clk_en_o,
    output logic [NUM_PORTS-1:0]       tx_en_o,
    output logic [NUM_PORTS-1:0]       rx_en_o
);
    typedef struct packed {
        logic hw_ctrl;
        logic rst_seen;
    } top_state_t;

    top_state_t top_d, top_q;
    logic [NUM_PORTS-1:0][REG_W-1:0] ctrl_all, adv_all;
    logic                            wr_ok;

    always_comb begin
        top_d = top_q;
        if (hw_rst_i) begin
            top_d.hw_ctrl  = mode_strap_i;
            top_d.rst_seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        top_q <= top_d;
    end

    assign hw_ctrl_o = top_q.hw_ctrl;
    assign wr_ok     = reg_wr_i && !top_q.hw_ctrl && !gpd_i;

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        phy_mgmt_port i_port (
            .clk      (clk),
            .hw_rst_i (hw_rst_i),
            .strap_i  (cfg_strap_i[p*REG_W +: REG_W]),
            .wr_en_i  (wr_ok && (int'(reg_port_i) == p)),
            .addr_i   (reg_addr_i),
            .wdata_i  (reg_wdata_i),
            .gpd_i    (gpd_i),
            .tx_req_i (tx_req_i[p]),
            .rx_req_i (rx_req_i[p]),
            .ctrl_o   (ctrl_all[p]),
            .adv_o    (adv_all[p]),
            .pd_o     (port_pd_o[p]),
            .clk_en_o (port_clk_en_o[p]),
            .tx_en_o  (tx_en_o[p]),
            .rx_en_o  (rx_en_o[p])
        );
    end

    phy_mgmt_rdmux #(.NUM_PORTS(NUM_PORTS), .PSEL_W(PSEL_W)) i_rdmux (
        .clk        (clk),
        .hw_rst_i   (hw_rst_i),
        .rd_i       (reg_rd_i),
        .port_i     (reg_port_i),
        .addr_i     (reg_addr_i),
        .gpd_i      (gpd_i),
        .ctrl_all_i (ctrl_all),
        .adv_all_i  (adv_all),
        .rdata_o    (reg_rdata_o),
        .rvalid_o   (reg_rvalid_o)
    );

    // R1: mode follows the strap sampled at hardware reset
    a_r1_mode_capture: assert property (@(posedge clk) disable iff (hw_rst_i || !top_q.rst_seen)
        $past(hw_rst_i) |-> hw_ctrl_o == $past(mode_strap_i));
    a_r1_mode_kept: assert property (@(posedge clk) disable iff (hw_rst_i || !top_q.rst_seen)
        reg_wr_i |=> $stable(hw_ctrl_o));
    // R2: strap control freezes every register against writes
    a_r2_hw_mode_freeze: assert property (@(posedge clk) disable iff (hw_rst_i || !top_q.rst_seen)
        hw_ctrl_o |=> $stable(ctrl_all) && $stable(adv_all));
    // R10: hardware reset overrides power-down and writes
    a_r10_rst_priority: assert property (@(posedge clk) disable iff (!top_q.rst_seen)
        hw_rst_i |=> adv_all[0] == ADV_DEFAULT && ctrl_all[0] == ($past(cfg_strap_i[REG_W-1:0]) & SWRST_MASK));
endmodule

// File: tb/test_phy_mgmt_ctrl.sv
module test_phy_mgmt_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NP = 8;
    localparam int DW = 16;
    localparam logic [DW-1:0] ADV_DEF = 16'h01E1;

    logic clk = 1'b0;
    logic hw_rst = 1'b1, mode_strap = 1'b0, gpd = 1'b0;
    logic [NP*DW-1:0] cfg_strap = '0;
    logic reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0] reg_port = '0;
    logic [4:0] reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0, reg_rdata;
    logic reg_rvalid, hw_ctrl;
    logic [NP-1:0] tx_req = '1, rx_req = '1;
    logic [NP-1:0] port_pd, port_clk_en, tx_en, rx_en;

    phy_mgmt_ctrl #(.NUM_PORTS(NP)) i_phy_mgmt_ctrl (
        .clk(clk), .hw_rst_i(hw_rst), .mode_strap_i(mode_strap), .cfg_strap_i(cfg_strap),
        .gpd_i(gpd), .reg_wr_i(reg_wr), .reg_rd_i(reg_rd), .reg_port_i(reg_port),
        .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
        .reg_rvalid_o(reg_rvalid), .tx_req_i(tx_req), .rx_req_i(rx_req),
        .hw_ctrl_o(hw_ctrl), .port_pd_o(port_pd), .port_clk_en_o(port_clk_en),
        .tx_en_o(tx_en), .rx_en_o(rx_en)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, errors = 0;
    bit done = 0;
    logic [DW-1:0] exp_q[$];
    string tag_q[$];
    logic [DW-1:0] m_ctrl[NP], m_adv[NP], m_lat[NP];
    bit m_hw;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Monitor: pops the scoreboard on each valid read
    always @(negedge clk) begin
        if (reg_rvalid === 1'b1) begin
            if (exp_q.size() == 0) chk("R9 unexpected rvalid", 1, 0);
            else chk(tag_q.pop_front(), reg_rdata, exp_q.pop_front());
        end
    end

    function automatic logic [DW-1:0] model_read(int p, int a);
        if (gpd) return '0;
        if (a == 0) return m_ctrl[p];
        if (a == 4) return m_adv[p];
        return '0;
    endfunction

    task automatic do_read(int p, int a, string tag);
        @(negedge clk);
        reg_rd = 1; reg_port = 3'(p); reg_addr = 5'(a);
        exp_q.push_back(model_read(p, a));
        tag_q.push_back(tag);
        @(negedge clk);
        reg_rd = 0;
        #1 chk("R9 read answered next cycle", exp_q.size(), 0);
    endtask

    task automatic do_write(int p, int a, logic [DW-1:0] d);
        @(negedge clk);
        reg_wr = 1; reg_port = 3'(p); reg_addr = 5'(a); reg_wdata = d;
        if (!gpd && !m_hw) begin
            if (a == 0) begin
                if (d[15]) begin m_ctrl[p] = m_lat[p]; m_adv[p] = ADV_DEF; end
                else m_ctrl[p] = d & 16'h7FFF;
            end else if (a == 4) m_adv[p] = d;
        end
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic do_hwreset(bit mode, logic [NP*DW-1:0] s);
        hw_rst = 1; mode_strap = mode; cfg_strap = s;
        @(negedge clk);
        hw_rst = 0;
        m_hw = mode;
        for (int p = 0; p < NP; p++) begin
            m_lat[p] = s[p*DW +: DW] & 16'h7FFF;
            m_ctrl[p] = m_lat[p]; m_adv[p] = ADV_DEF;
        end
    endtask

    task automatic chk_port(int p, bit pd, string tag);
        chk({tag, " pd"}, port_pd[p], pd);
        chk({tag, " clk_en"}, port_clk_en[p], !pd);
        chk({tag, " tx_en"}, tx_en[p], !pd);
        chk({tag, " rx_en"}, rx_en[p], !pd);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        checks++; errors++;
        $display("FAIL watchdog actual=running expected=finished");
        finish_run();
    end

    initial begin
        logic [NP*DW-1:0] s1, s2;
        for (int p = 0; p < NP; p++) begin
            s1[p*DW +: DW] = 16'h0100 + 16'(p * 16'h0011) | ((p == 3) ? 16'h8000 : 16'h0);
            s2[p*DW +: DW] = 16'h2000 + 16'(p);
        end
        @(negedge clk);
        do_hwreset(0, s1);
        chk("R1 mode low after reset", hw_ctrl, 0);
        chk("R9 rvalid idle after reset", reg_rvalid, 0);
        for (int p = 0; p < NP; p++) do_read(p, 0, "R3 ctrl from strap");
        do_read(3, 4, "R3 adv default");
        chk_port(0, 0, "R7 port up");

        // R5 per-port power-down and R7 gating
        do_write(2, 0, 16'h0900);
        chk_port(2, 1, "R5 port2 down");
        chk_port(1, 0, "R5 port1 unaffected");
        do_read(2, 0, "R5 reg readable while down");
        tx_req[1] = 0; #1 chk("R7 tx follows request", tx_en[1], 0); tx_req[1] = 1;

        // R4 software reset uses latched strap, not current pins
        do_write(2, 4, 16'hABCD);
        do_read(2, 4, "R4 adv written");
        cfg_strap = s2;
        do_write(2, 0, 16'h8000);
        do_read(2, 0, "R4 ctrl reloaded from snapshot");
        do_read(2, 4, "R4 adv back to default");
        chk_port(2, 0, "R4 port2 up again");

        // R8 unimplemented address
        do_write(5, 7, 16'hFFFF);
        do_read(5, 7, "R8 unimplemented reads zero");
        do_read(5, 0, "R8 ctrl unchanged");

        // R6 global power-down
        do_write(6, 4, 16'h1234);
        gpd = 1;
        #1 for (int p = 0; p < NP; p++) chk_port(p, 1, "R6 global down");
        do_read(6, 4, "R6 read zero under gpd");
        do_write(6, 4, 16'h5555);
        do_write(6, 0, 16'h8000);
        gpd = 0;
        do_read(6, 4, "R6 value kept after release");
        chk_port(6, 0, "R6 port6 up after release");

        // R10 hardware reset during gpd and write, selects strap mode
        gpd = 1;
        @(negedge clk);
        reg_wr = 1; reg_port = 3'd0; reg_addr = 5'd4; reg_wdata = 16'h7777;
        do_hwreset(1, s2);
        reg_wr = 0;
        chk("R1 mode high after reset", hw_ctrl, 1);
        gpd = 0;
        do_read(0, 4, "R10 reset beats write");
        do_read(0, 0, "R10 ctrl from new strap");

        // R2 strap mode ignores writes, reads still work
        do_write(4, 0, 16'h0800);
        chk_port(4, 0, "R2 write ignored power");
        do_read(4, 0, "R2 ctrl unchanged");
        do_write(4, 4, 16'h0000);
        do_read(4, 4, "R2 adv unchanged");
        chk("R1 mode held", hw_ctrl, 1);

        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule